// File: doc/BRIEF.md
# Four-Lane Pseudo-Random Sequence Checker with Latching Pass Flag

This block checks four received serial lanes, one bit per clock each, against a local pseudo-random bit sequence generator. The generator uses the 7-bit polynomial x^7 + x^6 + 1, so each bit is the XOR of the bits received 7 and 6 positions earlier. After reset each lane seeds its own generator from the first seven bits it receives. From then on the generator runs by itself and predicts every later bit. Each received bit is compared against that prediction, and the lane's pass flag is updated from the result.

A single sync-enable input chooses how the flag behaves on all lanes. When sync-enable is high, the first mismatch pulls the flag low and holds it there. When sync-enable is low, the flag is transparent and shows the result of the latest comparison. A two-bit report-enable field gates all four flags: the flags are shown only when both bits of the field are set, and they read 0 otherwise.

Each lane runs a small state machine with three states:
- **SEED**: seven received bits are loaded into the generator.
- **RUN**: the flag is live.
- **LATCHED**: the flag is held low.

The transitions are:
- SEED→RUN after the seventh seed bit.
- RUN→LATCHED on a mismatch while sync-enable is high.
- LATCHED→RUN once sync-enable is sampled low.
- Reset from any state→SEED.

Top module: `prbs_quad_checker`

## Requirements
- R1: An active-low reset (`rst_n` = 0) drives all four pass outputs to 0 at once, whatever the other inputs are. It returns every lane to SEED, so the next seven bits sampled after reset is released become the new seed.
- R2: During the seven SEED cycles the pass output of the lane stays 0. The eighth bit after reset is the first bit compared.
- R3: After seeding, the expected bit is b[n] = b[n-7] XOR b[n-6]. While a lane receives an unbroken sequence with this recurrence and report is enabled, its pass output is 1 in every comparison cycle.
- R4: With `sync_en` = 0, a single flipped bit drives the lane's pass output to 0 for exactly one cycle. The local generator keeps running from its own prediction and is not disturbed by the wrong bit, so the following correct bits give 1 again.
- R5: With `sync_en` = 1, the first mismatch drives the lane's pass output to 0. It stays 0 on every later cycle while `sync_en` remains 1, even if all later bits are correct.
- R6: Once `sync_en` is sampled 0 in LATCHED, the flag is released on that same edge. The pass output then shows the result of comparing that bit, and it follows live results from then on.
- R7: Unless `rpt_field` equals 2'b11, all pass outputs are 0 in the same cycle. Neither comparison, seeding nor latching is affected: restoring 2'b11 shows the state the lanes would have had anyway.
- R8: The four lanes are independent. An error or seed on one lane never changes the pass output of another lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one bit per lane is sampled on each rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 4 | Received bit, one per lane (bit i is lane i) |
| sync_en | input | 1 | 1: the flag latches low on the first error; 0: the flag is transparent |
| rpt_field | input | 2 | Report enable field; the flags are shown only when it is 2'b11 |
| pass_o | output | 4 | Pass flag per lane (bit i is lane i) |

## Verification
Each comparison is registered. The pass flag for a bit therefore appears just after the rising edge that samples that bit, and `sync_en` takes effect on that same edge. The report gate is combinational and acts in the cycle it changes.

The bench drives `rx_bit`, `sync_en` and `rpt_field` on the falling edge. It compares `pass_o` 2 ns after the next rising edge, against a model that advances one step for each bit it drives. Reset is checked while it is held, and seeding is checked over the seven cycles that follow its release.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

    typedef enum logic [1:0] {
        ST_SEED    = 2'd0,
        ST_RUN     = 2'd1,
        ST_LATCHED = 2'd2
    } lane_state_t;

    localparam logic [1:0] RPT_ON = 2'b11;

endpackage

// File: rtl/prbs_ref_gen.sv
module prbs_ref_gen #(
    parameter int W     = 7,
    parameter int TAP_A = 7,
    parameter int TAP_B = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic rx_bit,
    output logic exp_bit
);

    logic [W-1:0] sr_q;

    // prediction from the two taps of the recurrence
    assign exp_bit = sr_q[TAP_A-1] ^ sr_q[TAP_B-1];

    // while loading, capture received bits; afterwards run free
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= {sr_q[W-2:0], (load ? rx_bit : exp_bit)};
        end
    end

endmodule

// File: rtl/prbs_lane_fsm.sv
module prbs_lane_fsm
    import prbs_chk_pkg::*;
#(
    parameter int SEED_LEN = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_bit,
    input  logic exp_bit,
    input  logic sync_en,
    output logic seeding,
    output logic pass_q
);

    localparam int CW = $clog2(SEED_LEN + 1);

    lane_state_t     st_q, st_d;
    logic [CW-1:0]   cnt_q;
    logic            mism;
    logic            seed_done;

    assign mism      = rx_bit ^ exp_bit;
    assign seeding   = (st_q == ST_SEED);
    assign seed_done = (cnt_q == CW'(SEED_LEN - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_SEED;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= seeding ? cnt_q + CW'(1) : '0;
        end
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_SEED:    if (seed_done)       st_d = ST_RUN;
            ST_RUN:     if (mism && sync_en) st_d = ST_LATCHED;
            ST_LATCHED: if (!sync_en)        st_d = ST_RUN;
            default:                         st_d = ST_SEED;
        endcase
    end

    // registered pass flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pass_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_SEED:    pass_q <= 1'b0;
                ST_RUN:     pass_q <= !mism;
                ST_LATCHED: pass_q <= sync_en ? 1'b0 : !mism;
                default:    pass_q <= 1'b0;
            endcase
        end
    end

    // R1: seed counter stays inside the seed window
    p_seed_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        seeding |-> (int'(cnt_q) < SEED_LEN));

    // R2: no pass while the seed is being captured
    p_seed_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seeding |=> !pass_q);

    // R4: transparent flag mirrors the compared bit
    p_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && !sync_en) |=> (pass_q != $past(mism)));

    // R5: an error under sync-enable enters the latched state
    p_latch_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && mism && sync_en) |=> (st_q == ST_LATCHED));

    // R5: latched flag holds low while sync-enable stays high
    p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LATCHED && sync_en) |=> (!pass_q && st_q == ST_LATCHED));

    // R6: dropping sync-enable releases to live status
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LATCHED && !sync_en) |=> (st_q == ST_RUN && pass_q != $past(mism)));

endmodule

// File: rtl/prbs_quad_checker.sv
module prbs_quad_checker
    import prbs_chk_pkg::*;
#(
    parameter int LANES = 4,
    parameter int PRBS_W = 7,
    parameter int TAP_A = 7,
    parameter int TAP_B = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] rx_bit,
    input  logic             sync_en,
    input  logic [1:0]       rpt_field,
    output logic [LANES-1:0] pass_o
);

    logic [LANES-1:0] pass_q;
    logic [LANES-1:0] seeding;
    logic [LANES-1:0] exp_bit;
    logic             rpt_on;

    assign rpt_on = (rpt_field == RPT_ON);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        prbs_ref_gen #(
            .W     (PRBS_W),
            .TAP_A (TAP_A),
            .TAP_B (TAP_B)
        ) i_gen (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (seeding[i]),
            .rx_bit  (rx_bit[i]),
            .exp_bit (exp_bit[i])
        );

        prbs_lane_fsm #(
            .SEED_LEN (PRBS_W)
        ) i_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .rx_bit  (rx_bit[i]),
            .exp_bit (exp_bit[i]),
            .sync_en (sync_en),
            .seeding (seeding[i]),
            .pass_q  (pass_q[i])
        );

        assign pass_o[i] = rpt_on & pass_q[i];
    end

    // R7: a disabled report field never shows a pass
    always_comb begin
        if (rst_n && !rpt_on) begin
            p_report_gate_r7: assert (pass_o == '0);
        end
    end

endmodule

// File: tb/test_prbs_quad_checker.sv
`timescale 1ns/1ps
module test_prbs_quad_checker;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] rx_bit = '0;
    logic       sync_en = 1'b0;
    logic [1:0] rpt_field = 2'b11;
    logic [3:0] pass_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // transmit generators and reference model
    logic [6:0] tx_s  [4];
    logic [6:0] m_gen [4];
    int         m_cnt [4];
    bit         m_lat [4];
    bit         m_pq  [4];

    always #4 clk = ~clk;

    prbs_quad_checker i_prbs_quad_checker (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_bit    (rx_bit),
        .sync_en   (sync_en),
        .rpt_field (rpt_field),
        .pass_o    (pass_o)
    );

    function automatic logic prbs_next(input logic [6:0] s);
        return s[6] ^ s[5];
    endfunction

    task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: pass_o=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] model_out(input logic [1:0] r);
        logic [3:0] v;
        for (int l = 0; l < 4; l++) v[l] = m_pq[l];
        return (r == 2'b11) ? v : 4'b0000;
    endfunction

    task automatic model_reset();
        for (int l = 0; l < 4; l++) begin
            m_cnt[l] = 0; m_lat[l] = 0; m_pq[l] = 0; m_gen[l] = '0;
        end
    endtask

    // one bit per lane; called right after a falling edge
    task automatic cycle(input logic [3:0] err, input logic s, input logic [1:0] r,
                         input string tag);
        logic [3:0] bits;
        for (int l = 0; l < 4; l++) begin
            logic b;
            logic e;
            logic mm;
            b = prbs_next(tx_s[l]);
            tx_s[l] = {tx_s[l][5:0], b};
            bits[l] = b ^ err[l];
            if (m_cnt[l] < 7) begin
                m_gen[l] = {m_gen[l][5:0], bits[l]};
                m_cnt[l]++;
                m_pq[l] = 0;
            end else begin
                e  = prbs_next(m_gen[l]);
                m_gen[l] = {m_gen[l][5:0], e};
                mm = (bits[l] != e);
                if (m_lat[l]) begin
                    if (!s) begin m_lat[l] = 0; m_pq[l] = !mm; end
                    else m_pq[l] = 0;
                end else if (mm && s) begin
                    m_lat[l] = 1; m_pq[l] = 0;
                end else begin
                    m_pq[l] = !mm;
                end
            end
        end
        rx_bit = bits; sync_en = s; rpt_field = r;
        @(posedge clk); #2;
        check(pass_o, model_out(r), tag);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        model_reset();
        #1;
        check(pass_o, 4'b0000, "R1 reset asserted");
        for (int k = 0; k < 3; k++) begin
            rx_bit = 4'($urandom);
            @(posedge clk); #2;
            check(pass_o, 4'b0000, "R1 reset held");
            @(negedge clk);
        end
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int l = 0; l < 4; l++) tx_s[l] = 7'(($urandom % 127) + 1);
        @(negedge clk);
        do_reset();

        // seeding then clean stream, transparent
        for (int k = 0; k < 7; k++) cycle(4'b0000, 1'b0, 2'b11, "R2 seeding");
        for (int k = 0; k < 30; k++) cycle(4'b0000, 1'b0, 2'b11, "R3 clean stream");

        // single error, transparent; other lanes stay 1
        cycle(4'b0010, 1'b0, 2'b11, "R4 R8 single error transparent");
        for (int k = 0; k < 5; k++) cycle(4'b0000, 1'b0, 2'b11, "R4 recovery");
        cycle(4'b1000, 1'b0, 2'b11, "R4 R8 error lane 3");
        cycle(4'b0000, 1'b0, 2'b11, "R4 recovery");

        // latched mode
        for (int k = 0; k < 3; k++) cycle(4'b0000, 1'b1, 2'b11, "R5 clean latched mode");
        cycle(4'b0100, 1'b1, 2'b11, "R5 R8 first error latches");
        for (int k = 0; k < 10; k++) cycle(4'b0000, 1'b1, 2'b11, "R5 held low");
        cycle(4'b0100, 1'b1, 2'b11, "R5 second error");

        // release
        cycle(4'b0000, 1'b0, 2'b11, "R6 release");
        for (int k = 0; k < 4; k++) cycle(4'b0000, 1'b0, 2'b11, "R6 live");
        cycle(4'b0001, 1'b1, 2'b11, "R5 latch lane 0");
        cycle(4'b0001, 1'b0, 2'b11, "R6 release during error");
        cycle(4'b0000, 1'b0, 2'b11, "R6 live after release");

        // report gating does not touch state
        cycle(4'b0001, 1'b1, 2'b01, "R7 gated 01");
        cycle(4'b0000, 1'b1, 2'b10, "R7 gated 10");
        cycle(4'b0000, 1'b1, 2'b00, "R7 gated 00");
        cycle(4'b0000, 1'b1, 2'b11, "R7 restored shows latch");
        cycle(4'b0000, 1'b0, 2'b01, "R7 gated release");
        cycle(4'b0000, 1'b0, 2'b11, "R7 restored live");

        // constrained random
        begin
            logic       s = 1'b0;
            logic [1:0] r = 2'b11;
            for (int k = 0; k < 3000; k++) begin
                logic [3:0] e;
                for (int l = 0; l < 4; l++) e[l] = (($urandom % 16) == 0);
                if (($urandom % 32) == 0) s = ~s;
                if (($urandom % 64) == 0) r = (($urandom % 2) == 0) ? 2'b11 : 2'($urandom);
                cycle(e, s, r, "R8 random");
            end
        end

        // mid-run reset and reseed
        @(negedge clk);
        do_reset();
        for (int k = 0; k < 7; k++) cycle(4'b0000, 1'b1, 2'b11, "R1 R2 reseed");
        for (int k = 0; k < 10; k++) cycle(4'b0000, 1'b1, 2'b11, "R3 after reseed");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule